// File: doc/BRIEF.md
# Boundary-Scan Wrapped Dual Nine-Bit Latch

The block contains two separate banks of nine transparent latches, called A and B. Each bank has its own data inputs, its own latch enable and its own active-low output enable. Three-state pins are modelled as a value bus plus an active-high drive flag for each bank. While a bank's latch enable is high, its latched value follows the bank's data. When the enable falls, the bank keeps the value it had at that moment. Disabling a bank's outputs does not stop the bank from taking in new data.

A 42-cell boundary-scan register surrounds the two banks. It is clocked by the test clock and controlled by capture, shift and update strobes from an external TAP. Observe-only cells sit on all 22 system inputs. Observe-and-control cells sit on the 18 latch outputs and on the two internal active-high enables. The control cells have a second update stage. When the test-mode input is high, the update stage drives the pins in place of the latch logic. The serial output is retimed onto the falling test clock.

Top module: `bscan_dual_latch`

## Requirements
- R1: In normal mode (testMode low), while a bank's latch enable is high, that bank's pin value equals its data input.
- R2: When a bank's latch enable goes low, the pin value keeps the data present before the fall, and later data changes have no effect on it.
- R3: A high active-low enable clears that bank's drive flag. Data latched while the bank is disabled appears once the bank is enabled again.
- R4: The two banks are independent: the enables and data of one bank never change the other bank's pin value.
- R5: While rstN is low, the scan register, the update stage and scanOut are all zero. In test mode this makes all pin values and drive flags zero.
- R6: A rising tck with captureDr loads each observe cell with its pin and each output cell with the core value. For an enable cell the core value is the inverse of the active-low enable, and it is captured even when the bank is disabled.
- R7: Scan register bit positions: 0..8 B outputs[0..8], 9 B internal enable, 10..18 A outputs[0..8], 19 A internal enable, 20 B active-low enable, 21 B latch enable, 22..30 B data[0..8], 31 A active-low enable, 32 A latch enable, 33..41 A data[0..8]. Each shift moves every bit one place toward bit 0, and scanIn enters at bit 41. Bit 0 is the first bit to reach scanOut.
- R8: scanOut changes only on the falling tck. It shows the register's bit 0 as it stood after the preceding rising edge.
- R9: A rising tck with updateDr copies register bits 0..19 into the update stage. In test mode, bPinOut = bits 0..8, bPinDrive = bit 9, aPinOut = bits 10..18 and aPinDrive = bit 19.
- R10: In test mode the pins stay unchanged during capture and shift. Only an update changes them.
- R11: Clearing testMode returns the pins to the latch logic, and the latch contents are undisturbed.
- R12: When strobes coincide, capture takes precedence over shift, and shift takes precedence over update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low reset of the scan logic |
| aData | input | 9 | Bank A data inputs |
| aLatchEn | input | 1 | Bank A latch enable, high = transparent |
| aOutEnN | input | 1 | Bank A output enable, active low |
| bData | input | 9 | Bank B data inputs |
| bLatchEn | input | 1 | Bank B latch enable, high = transparent |
| bOutEnN | input | 1 | Bank B output enable, active low |
| scanIn | input | 1 | Serial scan input |
| captureDr | input | 1 | Capture strobe from the TAP |
| shiftDr | input | 1 | Shift strobe from the TAP |
| updateDr | input | 1 | Update strobe from the TAP |
| testMode | input | 1 | High: pins driven from the update stage |
| aPinOut | output | 9 | Bank A pin values |
| aPinDrive | output | 1 | Bank A drive flag, high = driven, low = high impedance |
| bPinOut | output | 9 | Bank B pin values |
| bPinDrive | output | 1 | Bank B drive flag |
| scanOut | output | 1 | Serial scan output, falling-edge timed |

## Verification
The assertions sample the asynchronous latch paths on the rising test clock. They therefore assume that system inputs and testMode stay constant across at least one rising edge, and that a latch-enable pulse never opens and closes between two edges. The stimulus changes every input shortly after a falling edge and holds each value for at least a full clock. The stability checks in test mode also assume that testMode was held over two successive edges, and the bench switches it only between scan sequences.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } scanStrobe_t;

  function automatic int chainLen(input int width);
    return 4 * width + 6;
  endfunction

  function automatic int ctlLen(input int width);
    return 2 * width + 2;
  endfunction
endpackage

// File: rtl/latch_bank.sv
module latch_bank #(
  parameter int WIDTH = 9
) (
  input  logic [WIDTH-1:0] din,
  input  logic             latchEn,
  input  logic             outEnN,
  output logic [WIDTH-1:0] q,
  output logic             coreEn
);
  always_latch begin
    if (latchEn) q <= din;
  end

  assign coreEn = ~outEnN;
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl (
  input  logic                    captureDr,
  input  logic                    shiftDr,
  input  logic                    updateDr,
  output bscan_pkg::scanStrobe_t  stb
);
  always_comb begin
    stb.capture = captureDr;
    stb.shift   = shiftDr & ~captureDr;
    stb.update  = updateDr & ~captureDr & ~shiftDr;
  end
endmodule

// File: rtl/scan_path.sv
module scan_path #(
  parameter int WIDTH = 9,
  localparam int LEN = bscan_pkg::chainLen(WIDTH),
  localparam int CTL = bscan_pkg::ctlLen(WIDTH)
) (
  input  logic                   tck,
  input  logic                   rstN,
  input  bscan_pkg::scanStrobe_t stb,
  input  logic                   scanIn,
  input  logic [LEN-1:0]         capVec,
  output logic [CTL-1:0]         updCtl,
  output logic                   scanOut
);
  logic [LEN-1:0] chain;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)            chain <= '0;
    else if (stb.capture) chain <= capVec;
    else if (stb.shift)   chain <= {scanIn, chain[LEN-1:1]};
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)           updCtl <= '0;
    else if (stb.update) updCtl <= chain[CTL-1:0];
  end

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) scanOut <= 1'b0;
    else       scanOut <= chain[0];
  end
endmodule

// File: rtl/bscan_dual_latch.sv
module bscan_dual_latch #(
  parameter int WIDTH = 9
) (
  input  logic             tck,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aData,
  input  logic             aLatchEn,
  input  logic             aOutEnN,
  input  logic [WIDTH-1:0] bData,
  input  logic             bLatchEn,
  input  logic             bOutEnN,
  input  logic             scanIn,
  input  logic             captureDr,
  input  logic             shiftDr,
  input  logic             updateDr,
  input  logic             testMode,
  output logic [WIDTH-1:0] aPinOut,
  output logic             aPinDrive,
  output logic [WIDTH-1:0] bPinOut,
  output logic             bPinDrive,
  output logic             scanOut
);
  localparam int LEN = bscan_pkg::chainLen(WIDTH);
  localparam int CTL = bscan_pkg::ctlLen(WIDTH);

  logic [WIDTH-1:0] aQ, bQ;
  logic             aEnCore, bEnCore;
  logic [LEN-1:0]   capVec;
  logic [CTL-1:0]   updCtl;
  bscan_pkg::scanStrobe_t stb;

  latch_bank #(.WIDTH(WIDTH)) bankA (
    .din(aData), .latchEn(aLatchEn), .outEnN(aOutEnN), .q(aQ), .coreEn(aEnCore));

  latch_bank #(.WIDTH(WIDTH)) bankB (
    .din(bData), .latchEn(bLatchEn), .outEnN(bOutEnN), .q(bQ), .coreEn(bEnCore));

  scan_ctrl ctrl (
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr), .stb(stb));

  // serial-in end first: A inputs, A controls, B inputs, B controls,
  // A enable, A outputs, B enable, B outputs (bit 0 nearest scanOut)
  assign capVec = {aData, aLatchEn, aOutEnN, bData, bLatchEn, bOutEnN,
                   aEnCore, aQ, bEnCore, bQ};

  scan_path #(.WIDTH(WIDTH)) path (
    .tck(tck), .rstN(rstN), .stb(stb), .scanIn(scanIn),
    .capVec(capVec), .updCtl(updCtl), .scanOut(scanOut));

  always_comb begin
    if (testMode) begin
      bPinOut   = updCtl[WIDTH-1:0];
      bPinDrive = updCtl[WIDTH];
      aPinOut   = updCtl[2*WIDTH:WIDTH+1];
      aPinDrive = updCtl[2*WIDTH+1];
    end else begin
      aPinOut   = aQ;
      aPinDrive = aEnCore;
      bPinOut   = bQ;
      bPinDrive = bEnCore;
    end
  end
endmodule

// File: rtl/bscan_dual_latch_chk.sv
module bscan_dual_latch_chk #(
  parameter int WIDTH = 9
) (
  input logic             tck,
  input logic             rstN,
  input logic [WIDTH-1:0] aData,
  input logic             aLatchEn,
  input logic             aOutEnN,
  input logic [WIDTH-1:0] bData,
  input logic             bLatchEn,
  input logic             bOutEnN,
  input logic             updateDr,
  input logic             testMode,
  input logic [WIDTH-1:0] aPinOut,
  input logic             aPinDrive,
  input logic [WIDTH-1:0] bPinOut,
  input logic             bPinDrive
);
  // R1
  a_transparent_chk: assert property (@(posedge tck) disable iff (!rstN)
    (aLatchEn && !testMode) |-> (aPinOut == aData));

  // R1
  b_transparent_chk: assert property (@(posedge tck) disable iff (!rstN)
    (bLatchEn && !testMode) |-> (bPinOut == bData));

  // R2
  a_hold_chk: assert property (@(posedge tck) disable iff (!rstN)
    (!aLatchEn && !$past(aLatchEn) && !testMode && !$past(testMode))
      |-> $stable(aPinOut));

  // R3
  a_disable_chk: assert property (@(posedge tck) disable iff (!rstN)
    (aOutEnN && !testMode) |-> !aPinDrive);

  // R3
  b_disable_chk: assert property (@(posedge tck) disable iff (!rstN)
    (bOutEnN && !testMode) |-> !bPinDrive);

  // R10
  no_ripple_chk: assert property (@(posedge tck) disable iff (!rstN)
    (testMode && $past(testMode) && !$past(updateDr))
      |-> ($stable(aPinOut) && $stable(bPinOut) && $stable(aPinDrive) && $stable(bPinDrive)));
endmodule

bind bscan_dual_latch bscan_dual_latch_chk #(.WIDTH(WIDTH)) chk (
  .tck(tck), .rstN(rstN), .aData(aData), .aLatchEn(aLatchEn), .aOutEnN(aOutEnN),
  .bData(bData), .bLatchEn(bLatchEn), .bOutEnN(bOutEnN), .updateDr(updateDr),
  .testMode(testMode), .aPinOut(aPinOut), .aPinDrive(aPinDrive),
  .bPinOut(bPinOut), .bPinDrive(bPinDrive));

// File: tb/tb_bscan_dual_latch.sv
`timescale 1ns/1ps
module tb_bscan_dual_latch;
  localparam int W = 9;
  localparam int LEN = 4 * W + 6;

  logic tck = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aData = '0, bData = '0;
  logic aLatchEn = 1'b0, aOutEnN = 1'b0, bLatchEn = 1'b0, bOutEnN = 1'b0;
  logic scanIn = 1'b0, captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0;
  logic testMode = 1'b1;
  logic [W-1:0] aPinOut, bPinOut;
  logic aPinDrive, bPinDrive, scanOut;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #5 tck = ~tck;

  bscan_dual_latch #(.WIDTH(W)) dut (
    .tck(tck), .rstN(rstN), .aData(aData), .aLatchEn(aLatchEn), .aOutEnN(aOutEnN),
    .bData(bData), .bLatchEn(bLatchEn), .bOutEnN(bOutEnN), .scanIn(scanIn),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr), .testMode(testMode),
    .aPinOut(aPinOut), .aPinDrive(aPinDrive), .bPinOut(bPinOut), .bPinDrive(bPinDrive),
    .scanOut(scanOut));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge tck);
    #1;
  endtask

  task automatic t_reset();
    #12;
    chk("R5 aPinOut", 64'(aPinOut), 0);
    chk("R5 drives", {aPinDrive, bPinDrive}, 0);
    chk("R5 scanOut", 64'(scanOut), 0);
    step();
    rstN = 1'b1;
    step();
    testMode = 1'b0;
  endtask

  task automatic t_transparent();
    aOutEnN = 1'b0;
    aLatchEn = 1'b1;
    foreach (aData[i]) begin end
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] p;
      p = (k == 0) ? 9'h1A5 : (k == 1) ? 9'h05A : (k == 2) ? 9'h1FF : 9'h000;
      aData = p;
      step();
      chk("R1 follow", 64'(aPinOut), 64'(p));
    end
    chk("R1 drive", 64'(aPinDrive), 1);
  endtask

  task automatic t_hold();
    aData = 9'h133;
    step();
    aLatchEn = 1'b0;
    step();
    aData = 9'h0CC;
    step();
    chk("R2 hold", 64'(aPinOut), 64'h133);
  endtask

  task automatic t_oe();
    aOutEnN = 1'b1;
    step();
    chk("R3 disabled", 64'(aPinDrive), 0);
    aData = 9'h0F0;
    aLatchEn = 1'b1;
    step();
    aLatchEn = 1'b0;
    step();
    aOutEnN = 1'b0;
    step();
    chk("R3 reenable drive", 64'(aPinDrive), 1);
    chk("R3 loaded while off", 64'(aPinOut), 64'h0F0);
  endtask

  task automatic t_indep();
    bOutEnN = 1'b0;
    bData = 9'h155;
    bLatchEn = 1'b1;
    step();
    chk("R4 b follows", 64'(bPinOut), 64'h155);
    chk("R4 a untouched", 64'(aPinOut), 64'h0F0);
    bLatchEn = 1'b0;
    step();
    bData = 9'h0AA;
    aData = 9'h00F;
    aLatchEn = 1'b1;
    step();
    aLatchEn = 1'b0;
    step();
    chk("R4 a new", 64'(aPinOut), 64'h00F);
    chk("R4 b kept", 64'(bPinOut), 64'h155);
  endtask

  task automatic t_capture();
    logic [LEN-1:0] got, exp;
    aData = 9'h1C3;
    bData = 9'h02A;
    bOutEnN = 1'b1;
    exp = {9'h1C3, 1'b0, 1'b0, 9'h02A, 1'b0, 1'b1, 1'b1, 9'h00F, 1'b0, 9'h155};
    step();
    captureDr = 1'b1;
    @(posedge tck);
    #1;
    chk("R8 no change at rise", 64'(scanOut), 0);
    step();
    captureDr = 1'b0;
    got[0] = scanOut;
    chk("R8 bit0 after fall", 64'(scanOut), 1);
    for (int i = 1; i < LEN; i++) begin
      shiftDr = 1'b1;
      step();
      got[i] = scanOut;
    end
    shiftDr = 1'b0;
    chk("R6 enable cells", {got[19], got[9]}, 2'b10);
    chk("R7 chain image", 64'(got), 64'(exp));
  endtask

  task automatic t_update();
    logic [LEN-1:0] v;
    int ripple;
    v = '0;
    v[19:0] = {1'b1, 9'h0A5, 1'b0, 9'h15A};
    v[LEN-1:20] = 22'h2A5A5A;
    for (int j = 0; j < LEN; j++) begin
      scanIn = v[j];
      shiftDr = 1'b1;
      step();
    end
    shiftDr = 1'b0;
    scanIn = 1'b0;
    updateDr = 1'b1;
    step();
    updateDr = 1'b0;
    testMode = 1'b1;
    step();
    chk("R9 a pins", 64'(aPinOut), 64'h0A5);
    chk("R9 b pins", 64'(bPinOut), 64'h15A);
    chk("R9 drives", {aPinDrive, bPinDrive}, 2'b10);
    ripple = 0;
    for (int j = 0; j < LEN; j++) begin
      shiftDr = 1'b1;
      step();
      if (aPinOut !== 9'h0A5 || bPinOut !== 9'h15A || aPinDrive !== 1'b1) ripple++;
    end
    shiftDr = 1'b0;
    captureDr = 1'b1;
    step();
    captureDr = 1'b0;
    step();
    if (aPinOut !== 9'h0A5 || bPinOut !== 9'h15A) ripple++;
    chk("R10 no ripple", 64'(ripple), 0);
  endtask

  task automatic t_priority();
    // chain currently holds a capture; refill with zeros, then all strobes at once
    for (int j = 0; j < LEN; j++) begin
      shiftDr = 1'b1;
      step();
    end
    captureDr = 1'b1;
    shiftDr = 1'b1;
    updateDr = 1'b1;
    step();
    captureDr = 1'b0;
    shiftDr = 1'b0;
    updateDr = 1'b0;
    chk("R12 capture wins", 64'(scanOut), 1);
    chk("R12 no update", 64'(aPinOut), 64'h0A5);
  endtask

  task automatic t_leave();
    testMode = 1'b0;
    step();
    chk("R11 a back to latch", 64'(aPinOut), 64'h00F);
    chk("R11 b back to latch", 64'(bPinOut), 64'h155);
    chk("R11 drives", {aPinDrive, bPinDrive}, 2'b10);
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_hold();
    t_oe();
    t_indep();
    t_capture();
    t_update();
    t_priority();
    t_leave();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule